// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps the time of day and the calendar date: seconds, minutes, hours, a day-of-week count, day of month, month and a three-digit year. A divider counts enable pulses of a 32.768 kHz base clock and produces a one-second strobe. On that strobe the time advances by one second, with carries rippling through the date. The carries follow the month lengths and the Gregorian leap-year rule.

Software sees every field in BCD. A field is loaded through a per-field write strobe that shares one BCD data bus. The master run enable gates both the divider and all writes. The one-second strobe is exported so that neighbouring logic (alarm compare, tick logic) can sample the new time in the cycle it becomes valid.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00, day of week 0, day of month 01, month 01, year 000, and `secPulse` is low.
- R2: Once `runEn` is high, the divider loads `DIV_COUNT` in the cycle `runEn` rises, and a `baseTick` in that cycle is not counted. The time advances on the edge that takes the `DIV_COUNT`-th counted `baseTick`. `secPulse` is high for exactly the one cycle in which the new time is first visible.
- R3: While `runEn` is low the divider is frozen and no second elapses. A later rising edge of `runEn` discards any partial count and starts a full `DIV_COUNT` again.
- R4: Seconds wrap 59→00 and carry into minutes. Minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and produce a day carry.
- R5: On a day carry the day of week goes up by one and wraps 6→0, whatever the day of month does.
- R6: On a day carry the day of month goes up by one and wraps to 01 once it passes the month's length (Jan 31, Feb 28/29, Mar 31, Apr 30, May 31, Jun 30, Jul 31, Aug 31, Sep 30, Oct 31, Nov 30, Dec 31). That wrap advances the month, and December wraps to January with the year incremented.
- R7: The year value is an offset from 1900. February has 29 days when 1900+year is divisible by 4 and either not by 100 or by 400. Year 000 is not a leap year; years 100 and 124 are.
- R8: Month is written and read as BCD 01..12, with 01 meaning January.
- R9: The year port carries three BCD digits: bits [7:0] hold tens and units, bits [11:8] hold hundreds. The year wraps 999→000.
- R10: `wrStrobe` bits select the field: bit 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. A set bit loads that field from `wrData` on the next edge only while `runEn` is high. With `runEn` low the write has no effect.
- R11: When a write and a second advance land on the same edge, the written field takes the written value. The other fields still advance from the carries of the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseTick | input | 1 | One-cycle enable at the 32.768 kHz base rate |
| runEn | input | 1 | Master run enable; gates divider and writes |
| wrStrobe | input | 7 | Per-field write strobes (bit map in R10) |
| wrData | input | 12 | BCD write data; [11:8] used only for the year |
| secBcd | output | 8 | Seconds, BCD |
| minBcd | output | 8 | Minutes, BCD |
| hourBcd | output | 8 | Hours, BCD |
| wdayBcd | output | 8 | Day of week 0..6, BCD |
| mdayBcd | output | 8 | Day of month, BCD |
| monBcd | output | 8 | Month 01..12, BCD |
| yearBcd | output | 12 | Year, three BCD digits |
| secPulse | output | 1 | One-cycle strobe marking a new second |

## Verification
A field write shows on the outputs one edge after the strobe is sampled. A second advance shows, together with `secPulse`, one edge after the `DIV_COUNT`-th counted `baseTick`. Stimulus is driven on the falling edge, and outputs are read on the next falling edge, half a period after the register that updates them. The bench shrinks `DIV_COUNT` to 4 and counts `secPulse` at every falling edge of a tick burst. This pins the restart point and the ignored rise-cycle tick to the exact cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int FLD_N    = 7;
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_WDAY = 3;
  localparam int FLD_MDAY = 4;
  localparam int FLD_MON  = 5;
  localparam int FLD_YEAR = 6;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic             adv;
    logic [FLD_N-1:0] wr;
  } calCtl_t;

  function automatic logic [7:0] toBcd2(input logic [7:0] v);
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [7:0] fromBcd2(input logic [7:0] b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction

  function automatic logic isLeap(input int y);
    return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
  endfunction

  // month index is zero based
  function automatic logic [7:0] monthDays(input logic [3:0] m, input logic leap);
    case (m)
      4'd1:                      return leap ? 8'd29 : 8'd28;
      4'd3, 4'd5, 4'd8, 4'd10:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseTick,
  input  logic             runEn,
  input  logic [FLD_N-1:0] wrReq,
  output calCtl_t          ctl,
  output logic             secPulse
);

  localparam int CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DIV_COUNT - 1);

  logic             runQ;
  logic [CNT_W-1:0] divCnt;
  logic             pulseQ;
  logic             rise;
  logic             counting;
  logic             adv;

  assign rise     = runEn && !runQ;
  assign counting = runEn && runQ && baseTick;
  assign adv      = counting && (divCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      divCnt <= LOAD;
      pulseQ <= 1'b0;
    end else begin
      runQ   <= runEn;
      pulseQ <= adv;
      if (rise)
        divCnt <= LOAD;
      else if (counting)
        divCnt <= (divCnt == '0) ? LOAD : divCnt - 1'b1;
    end
  end

  always_comb begin
    ctl.adv = adv;
    ctl.wr  = wrReq & {FLD_N{runEn}};
  end

  assign secPulse = pulseQ;

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24,
  parameter int WDAY_LIMIT = 7,
  parameter int MON_LIMIT  = 12,
  parameter int YEAR_LIMIT = 1000,
  parameter int YEAR_BASE  = 1900
) (
  input  logic        clk,
  input  logic        rstN,
  input  calCtl_t     ctl,
  input  logic [11:0] wrData,
  output logic [7:0]  secBcd,
  output logic [7:0]  minBcd,
  output logic [7:0]  hourBcd,
  output logic [7:0]  wdayBcd,
  output logic [7:0]  mdayBcd,
  output logic [7:0]  monBcd,
  output logic [11:0] yearBcd
);

  localparam int WRAP_N = 4;   // seconds, minutes, hours, day of week
  localparam int WRAP_LIM [WRAP_N] = '{SEC_LIMIT, MIN_LIMIT, HOUR_LIMIT, WDAY_LIMIT};
  localparam int YEAR_W = $clog2(YEAR_LIMIT);

  logic [7:0]        wrVal;
  logic [YEAR_W-1:0] yearWr;
  logic [7:0]        wrapCnt [WRAP_N];
  logic [WRAP_N-1:0] carry;    // carry[i] advances field i
  logic              dayCarry;

  logic [7:0]        mday;
  logic [3:0]        mon;
  logic [YEAR_W-1:0] year;
  logic [7:0]        mdayInc;
  logic [3:0]        monInc;
  logic [YEAR_W-1:0] yearInc;
  logic              leap;
  logic              monCarry;
  logic              yearCarry;

  assign wrVal    = fromBcd2(wrData[7:0]);
  assign yearWr   = YEAR_W'(int'(fromBcd2(wrData[7:0])) + int'(wrData[11:8]) * 100);
  assign carry[0] = ctl.adv;

  generate
    for (genvar i = 0; i < WRAP_N; i++) begin : g_wrap
      logic [7:0] inc;
      logic       wrapHit;
      assign inc     = wrapCnt[i] + 8'd1;
      assign wrapHit = inc >= 8'(WRAP_LIM[i]);
      if (i + 1 < WRAP_N) begin : g_chain
        assign carry[i+1] = carry[i] && wrapHit;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          wrapCnt[i] <= 8'd0;
        else if (ctl.wr[i])
          wrapCnt[i] <= wrVal;
        else if (carry[i])
          wrapCnt[i] <= wrapHit ? 8'd0 : inc;
      end
    end
  endgenerate

  // hours roll over: same condition that advances the day of week
  assign dayCarry = carry[WRAP_N-1] && (wrapCnt[FLD_HOUR] + 8'd1 >= 8'(HOUR_LIMIT));

  always_comb begin
    leap      = isLeap(int'(year) + YEAR_BASE);
    mdayInc   = mday + 8'd1;
    monInc    = mon + 4'd1;
    yearInc   = year + 1'b1;
    monCarry  = dayCarry && (mdayInc > monthDays(mon, leap));
    yearCarry = monCarry && (monInc >= 4'(MON_LIMIT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mday <= 8'd1;
      mon  <= 4'd0;
      year <= '0;
    end else begin
      if (ctl.wr[FLD_MDAY])
        mday <= wrVal;
      else if (dayCarry)
        mday <= monCarry ? 8'd1 : mdayInc;

      if (ctl.wr[FLD_MON])
        mon <= 4'(wrVal - 8'd1);
      else if (monCarry)
        mon <= yearCarry ? 4'd0 : monInc;

      if (ctl.wr[FLD_YEAR])
        year <= yearWr;
      else if (yearCarry)
        year <= (int'(yearInc) >= YEAR_LIMIT) ? '0 : yearInc;
    end
  end

  always_comb begin
    secBcd  = toBcd2(wrapCnt[FLD_SEC]);
    minBcd  = toBcd2(wrapCnt[FLD_MIN]);
    hourBcd = toBcd2(wrapCnt[FLD_HOUR]);
    wdayBcd = toBcd2(wrapCnt[FLD_WDAY]);
    mdayBcd = toBcd2(mday);
    monBcd  = toBcd2(8'(mon) + 8'd1);
    yearBcd = {4'(year / YEAR_W'(100)), toBcd2(8'(year % YEAR_W'(100)))};
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseTick,
  input  logic             runEn,
  input  logic [FLD_N-1:0] wrStrobe,
  input  logic [11:0]      wrData,
  output logic [7:0]       secBcd,
  output logic [7:0]       minBcd,
  output logic [7:0]       hourBcd,
  output logic [7:0]       wdayBcd,
  output logic [7:0]       mdayBcd,
  output logic [7:0]       monBcd,
  output logic [11:0]      yearBcd,
  output logic             secPulse
);

  calCtl_t ctl;

  cal_ctrl #(.DIV_COUNT(DIV_COUNT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .baseTick (baseTick),
    .runEn    (runEn),
    .wrReq    (wrStrobe),
    .ctl      (ctl),
    .secPulse (secPulse)
  );

  cal_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (wrData),
    .secBcd  (secBcd),
    .minBcd  (minBcd),
    .hourBcd (hourBcd),
    .wdayBcd (wdayBcd),
    .mdayBcd (mdayBcd),
    .monBcd  (monBcd),
    .yearBcd (yearBcd)
  );

endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             baseTick,
  input logic             runEn,
  input logic [FLD_N-1:0] wrStrobe,
  input logic [7:0]       secBcd,
  input logic [7:0]       wdayBcd,
  input logic [7:0]       monBcd,
  input logic             secPulse
);

  // R2
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> ($past(runEn) && $past(baseTick)));

  // R3
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runEn) |=> !secPulse);

  // R10
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> ($stable(secBcd) && $stable(wdayBcd) && $stable(monBcd)));

  // R4
  sec_moves_on_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($changed(secBcd) && !$past(runEn && wrStrobe[FLD_SEC])) |-> secPulse);

  // R5
  wday_moves_on_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!secPulse && !$past(runEn && wrStrobe[FLD_WDAY])) |-> $stable(wdayBcd));

endmodule

bind bcd_calendar cal_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .baseTick (baseTick),
  .runEn    (runEn),
  .wrStrobe (wrStrobe),
  .secBcd   (secBcd),
  .wdayBcd  (wdayBcd),
  .monBcd   (monBcd),
  .secPulse (secPulse)
);

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NVEC       = 13;

  logic        clk = 1'b0;
  logic        rstN;
  logic        baseTick;
  logic        runEn;
  logic [6:0]  wrStrobe;
  logic [11:0] wrData;
  logic [7:0]  secBcd, minBcd, hourBcd, wdayBcd, mdayBcd, monBcd;
  logic [11:0] yearBcd;
  logic        secPulse;

  int total = 0;
  int bad   = 0;

  bcd_calendar #(.DIV_COUNT(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .runEn(runEn),
    .wrStrobe(wrStrobe), .wrData(wrData),
    .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd), .wdayBcd(wdayBcd),
    .mdayBcd(mdayBcd), .monBcd(monBcd), .yearBcd(yearBcd), .secPulse(secPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // inputs written, then expected after one second
  typedef struct packed {
    logic [7:0] s, mi, h, wd, md, mo; logic [11:0] y;
    logic [7:0] es, emi, eh, ewd, emd, emo; logic [11:0] ey;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,12'h024, 8'h01,8'h00,8'h00,8'h00,8'h01,8'h01,12'h024}, // R4
    '{8'h59,8'h00,8'h05,8'h01,8'h10,8'h06,12'h024, 8'h00,8'h01,8'h05,8'h01,8'h10,8'h06,12'h024}, // R4
    '{8'h59,8'h59,8'h10,8'h01,8'h10,8'h06,12'h024, 8'h00,8'h00,8'h11,8'h01,8'h10,8'h06,12'h024}, // R4
    '{8'h59,8'h59,8'h23,8'h06,8'h15,8'h03,12'h023, 8'h00,8'h00,8'h00,8'h00,8'h16,8'h03,12'h023}, // R5
    '{8'h59,8'h59,8'h23,8'h02,8'h30,8'h04,12'h023, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h05,12'h023}, // R6
    '{8'h59,8'h59,8'h23,8'h04,8'h31,8'h12,12'h099, 8'h00,8'h00,8'h00,8'h05,8'h01,8'h01,12'h100}, // R6 R9
    '{8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,12'h100, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,12'h100}, // R7
    '{8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,12'h000, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,12'h000}, // R7
    '{8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,12'h124, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,12'h124}, // R7
    '{8'h59,8'h59,8'h23,8'h01,8'h29,8'h02,12'h124, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,12'h124}, // R7
    '{8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,12'h123, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,12'h123}, // R7
    '{8'h59,8'h59,8'h23,8'h03,8'h31,8'h12,12'h999, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h01,12'h000}, // R9
    '{8'h59,8'h59,8'h23,8'h05,8'h31,8'h01,12'h050, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h02,12'h050}  // R6 R8
  };

  function automatic string vecTag(input int i);
    case (i)
      0, 1, 2:          return "R4 R8";
      3:                return "R5 R8";
      4, 5, 12:         return "R6 R8";
      6, 7, 8, 9, 10:   return "R7 R8";
      default:          return "R9 R8";
    endcase
  endfunction

  task automatic checkVal(input string tag, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeField(input int bitIdx, input logic [11:0] d);
    wrStrobe = 7'(1 << bitIdx);
    wrData   = d;
    @(negedge clk);
    wrStrobe = '0;
  endtask

  task automatic runTicks(input int n, output int pulses);
    pulses   = 0;
    baseTick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulses += int'(secPulse);
    end
    baseTick = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    summary();
  end

  initial begin
    int p;
    rstN = 1'b0; baseTick = 1'b0; runEn = 1'b0; wrStrobe = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkVal("R1 sec",   12'(secBcd),  12'h00);
    checkVal("R1 min",   12'(minBcd),  12'h00);
    checkVal("R1 hour",  12'(hourBcd), 12'h00);
    checkVal("R1 wday",  12'(wdayBcd), 12'h00);
    checkVal("R1 mday",  12'(mdayBcd), 12'h01);
    checkVal("R1 mon",   12'(monBcd),  12'h01);
    checkVal("R1 year",  yearBcd,      12'h000);
    checkVal("R1 pulse", 12'(secPulse), 12'h0);

    // R10 writes ignored while disabled
    writeField(0, 12'h030);
    writeField(5, 12'h007);
    checkVal("R10 sec write while off", 12'(secBcd), 12'h00);
    checkVal("R10 mon write while off", 12'(monBcd), 12'h01);

    // R3 ticks while disabled do nothing
    runTicks(3 * DIV, p);
    checkVal("R3 pulses while off", 12'(p), 12'd0);
    checkVal("R3 sec while off", 12'(secBcd), 12'h00);

    // R2 exact count after enable
    runEn = 1'b1;
    @(negedge clk);
    runTicks(DIV - 1, p);
    checkVal("R2 no early pulse", 12'(p), 12'd0);
    checkVal("R2 sec before count", 12'(secBcd), 12'h00);
    runTicks(1, p);
    checkVal("R2 pulse on last tick", 12'(p), 12'd1);
    checkVal("R2 sec advanced", 12'(secBcd), 12'h01);
    @(negedge clk);
    checkVal("R2 pulse one cycle", 12'(secPulse), 12'h0);

    // R2 tick in the rise cycle not counted
    runEn = 1'b0;
    @(negedge clk);
    runEn = 1'b1; baseTick = 1'b1;
    @(negedge clk);
    checkVal("R2 rise cycle pulse", 12'(secPulse), 12'h0);
    runTicks(DIV - 1, p);
    checkVal("R2 rise tick ignored", 12'(p), 12'd0);
    runTicks(1, p);
    checkVal("R2 pulse after rise", 12'(p), 12'd1);
    checkVal("R2 sec after rise", 12'(secBcd), 12'h02);

    // R3 partial count discarded on re-enable
    runTicks(2, p);
    runEn = 1'b0;
    runTicks(3, p);
    checkVal("R3 no pulse while paused", 12'(p), 12'd0);
    runEn = 1'b1;
    @(negedge clk);
    runTicks(DIV - 1, p);
    checkVal("R3 full restart", 12'(p), 12'd0);
    runTicks(1, p);
    checkVal("R3 pulse after restart", 12'(p), 12'd1);
    checkVal("R3 sec after restart", 12'(secBcd), 12'h03);

    // calendar vectors: bits 0 sec,1 min,2 hour,3 wday,4 mday,5 mon,6 year
    for (int i = 0; i < NVEC; i++) begin
      writeField(0, 12'(VECS[i].s));
      writeField(1, 12'(VECS[i].mi));
      writeField(2, 12'(VECS[i].h));
      writeField(3, 12'(VECS[i].wd));
      writeField(4, 12'(VECS[i].md));
      writeField(5, 12'(VECS[i].mo));
      writeField(6, VECS[i].y);
      checkVal({vecTag(i), " R10 write mon"}, 12'(monBcd), 12'(VECS[i].mo));
      checkVal({vecTag(i), " R9 write year"}, yearBcd, VECS[i].y);
      runTicks(DIV, p);
      checkVal({vecTag(i), " R2 pulse"}, 12'(p), 12'd1);
      checkVal({vecTag(i), " sec"},  12'(secBcd),  12'(VECS[i].es));
      checkVal({vecTag(i), " min"},  12'(minBcd),  12'(VECS[i].emi));
      checkVal({vecTag(i), " hour"}, 12'(hourBcd), 12'(VECS[i].eh));
      checkVal({vecTag(i), " wday"}, 12'(wdayBcd), 12'(VECS[i].ewd));
      checkVal({vecTag(i), " mday"}, 12'(mdayBcd), 12'(VECS[i].emd));
      checkVal({vecTag(i), " mon"},  12'(monBcd),  12'(VECS[i].emo));
      checkVal({vecTag(i), " year"}, yearBcd,      VECS[i].ey);
    end

    // R11 write and advance on the same edge
    writeField(0, 12'h059);
    writeField(1, 12'h007);
    writeField(2, 12'h005);
    runTicks(DIV - 1, p);
    wrStrobe = 7'b000_0001; wrData = 12'h010; baseTick = 1'b1;
    @(negedge clk);
    wrStrobe = '0; baseTick = 1'b0;
    checkVal("R11 written sec wins", 12'(secBcd), 12'h10);
    checkVal("R11 minute still carries", 12'(minBcd), 12'h08);
    checkVal("R11 pulse", 12'(secPulse), 12'h1);

    // R10 writes ignored after disabling a running clock
    runEn = 1'b0;
    @(negedge clk);
    writeField(2, 12'h011);
    writeField(6, 12'h321);
    checkVal("R10 hour kept", 12'(hourBcd), 12'h05);
    checkVal("R10 year kept", yearBcd, 12'h050);

    summary();
  end

endmodule